// File: doc/BRIEF.md
# I2C Slave Address Recognizer

This block sits behind a bit-level I2C receiver and decides, one byte at a time, whether this device is the target of a bus transaction. The receiver hands it single-cycle strobes for a START (or repeated START), for a STOP and for each fully received byte. The block compares only the first byte after each START with a stored 7-bit address and a stored compare bit. It then reports whether the device has been addressed, whether a general call was seen, and raises a one-cycle interrupt request when either holds.

Two addressing modes are offered. In 7-bit mode the direction bit is left out of the comparison. In 10-bit mode all eight bits of the first byte must equal the stored address followed by the compare bit. The byte that follows a matching first byte is presented on its own strobe so that software can check the low address bits. Software can then set the compare bit to 1, so that the read request sent after a repeated START is recognised. The mode input is taken only while the bus is idle.

Top module: `iic_addr_recognizer`

## Requirements
- R1: After reset, addressed_o, gcall_o, irq_o and sec_vld_o are all 0.
- R2: In 7-bit mode (ten_bit_i = 0), bits [7:1] of the first byte after a START are compared with the stored address. Bit 0, the direction bit, is ignored. On equality addressed_o becomes 1 and gcall_o becomes 0.
- R3: In 10-bit mode, bits [7:1] must equal the stored address and bit 0 must equal the stored compare bit. A difference in bit 0 alone is a mismatch.
- R4: A first byte whose bits [7:1] are all zero is a general call in either mode, whatever the value of bit 0. It sets gcall_o, clears addressed_o and raises irq_o. This holds even when the stored address is zero.
- R5: A first byte that is neither a general call nor a match clears both flags and raises no interrupt.
- R6: Only the first byte after a START or repeated START is evaluated. Later bytes, and bytes received with no START since the last STOP, leave both flags unchanged and raise no interrupt.
- R7: A STOP clears addressed_o and gcall_o and ends the transaction. A STOP wins over a byte strobe in the same cycle.
- R8: irq_o is high for exactly one cycle, the cycle after the evaluated byte's strobe. The flags take their new values in that same cycle.
- R9: In 10-bit mode, the byte following a matching first byte is output on sec_byte_o, with sec_vld_o high for the one cycle after its strobe. The flags are left unchanged.
- R10: ten_bit_i is sampled only while no transaction is open, from reset or STOP until a START. A change during a transaction has no effect until after the next STOP.
- R11: cfg_wr_i loads cfg_addr_i and cfg_rw_i at any time. Setting the compare bit to 1 after the second byte makes the first byte with direction bit 1 match after a repeated START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_i | input | 1 | Load strobe for the stored address and compare bit |
| cfg_addr_i | input | 7 | Stored slave address value |
| cfg_rw_i | input | 1 | Stored compare bit value |
| ten_bit_i | input | 1 | Mode select: 1 = 10-bit, 0 = 7-bit |
| start_i | input | 1 | START or repeated START strobe |
| stop_i | input | 1 | STOP strobe |
| byte_vld_i | input | 1 | Received byte strobe |
| byte_i | input | 8 | Received byte, direction bit in bit 0 |
| addressed_o | output | 1 | Device addressed as slave |
| gcall_o | output | 1 | General call received |
| irq_o | output | 1 | One-cycle interrupt request |
| sec_vld_o | output | 1 | Second 10-bit address byte valid |
| sec_byte_o | output | 8 | Second 10-bit address byte |

## Verification
Every result is a single register stage behind its strobe. The flags, irq_o and sec_vld_o change at the first rising edge that sees the byte strobe, and a configuration load or a START takes effect at the edge that captures it. The bench drives every strobe for one cycle, from one falling edge to the next. It reads the results at that next falling edge, half a cycle after the capturing edge. It then steps one more cycle to confirm that irq_o and sec_vld_o have dropped again.

// File: rtl/iic_arx_pkg.sv
package iic_arx_pkg;
  localparam int unsigned ADDR_W = 7;
  localparam int unsigned BYTE_W = ADDR_W + 1;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic              rw;
  } own_cfg_t;

  // General call: every address bit clear, direction bit not looked at.
  function automatic logic f_gcall(input logic [BYTE_W-1:0] b);
    return b[BYTE_W-1:1] == '0;
  endfunction

  // Own-address hit; 10-bit mode also folds the direction bit into the compare.
  function automatic logic f_hit(input logic [BYTE_W-1:0] b,
                                 input own_cfg_t cfg,
                                 input logic ten);
    logic upper_eq;
    upper_eq = (b[BYTE_W-1:1] == cfg.addr);
    return ten ? (upper_eq && (b[0] == cfg.rw)) : upper_eq;
  endfunction
endpackage

// File: rtl/iic_arx_cfg.sv
module iic_arx_cfg
  import iic_arx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_i,
  input  logic [ADDR_W-1:0] cfg_addr_i,
  input  logic              cfg_rw_i,
  input  logic              ten_bit_i,
  input  logic              bus_busy_i,
  output own_cfg_t          cfg_o,
  output logic              ten_q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_o <= '0;
    end else if (cfg_wr_i) begin
      cfg_o.addr <= cfg_addr_i;
      cfg_o.rw   <= cfg_rw_i;
    end
  end

  // Mode is frozen for the length of a transaction.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          ten_q_o <= 1'b0;
    else if (!bus_busy_i) ten_q_o <= ten_bit_i;
  end
endmodule

// File: rtl/iic_arx_cmp.sv
module iic_arx_cmp
  import iic_arx_pkg::*;
(
  input  logic [BYTE_W-1:0] byte_i,
  input  own_cfg_t          cfg_i,
  input  logic              ten_i,
  output logic              gc_hit_o,
  output logic              own_hit_o
);
  always_comb begin
    gc_hit_o  = f_gcall(byte_i);
    own_hit_o = f_hit(byte_i, cfg_i, ten_i);
  end
endmodule

// File: rtl/iic_arx_seq.sv
module iic_arx_seq
  import iic_arx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              byte_vld_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              ten_i,
  input  logic              gc_hit_i,
  input  logic              own_hit_i,
  output logic              busy_o,
  output logic              expect_o,
  output logic              addr_evt_o,
  output logic              addressed_o,
  output logic              gcall_o,
  output logic              irq_o,
  output logic              sec_vld_o,
  output logic [BYTE_W-1:0] sec_byte_o
);
  logic sec_pend_q;
  logic sec_evt;
  logic quiet;

  // Priority: STOP, then START, then a byte strobe.
  assign quiet      = !start_i && !stop_i;
  assign addr_evt_o = byte_vld_i && expect_o && quiet;
  assign sec_evt    = byte_vld_i && sec_pend_q && quiet;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_o      <= 1'b0;
      expect_o    <= 1'b0;
      sec_pend_q  <= 1'b0;
      addressed_o <= 1'b0;
      gcall_o     <= 1'b0;
    end else if (stop_i) begin
      busy_o      <= 1'b0;
      expect_o    <= 1'b0;
      sec_pend_q  <= 1'b0;
      addressed_o <= 1'b0;
      gcall_o     <= 1'b0;
    end else if (start_i) begin
      busy_o     <= 1'b1;
      expect_o   <= 1'b1;
      sec_pend_q <= 1'b0;
    end else if (addr_evt_o) begin
      expect_o    <= 1'b0;
      gcall_o     <= gc_hit_i;
      addressed_o <= !gc_hit_i && own_hit_i;
      sec_pend_q  <= ten_i && !gc_hit_i && own_hit_i;
    end else if (sec_evt) begin
      sec_pend_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_o      <= 1'b0;
      sec_vld_o  <= 1'b0;
      sec_byte_o <= '0;
    end else begin
      irq_o     <= addr_evt_o && (gc_hit_i || own_hit_i);
      sec_vld_o <= sec_evt;
      if (sec_evt) sec_byte_o <= byte_i;
    end
  end
endmodule

// File: rtl/iic_addr_recognizer.sv
module iic_addr_recognizer
  import iic_arx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_i,
  input  logic [ADDR_W-1:0] cfg_addr_i,
  input  logic              cfg_rw_i,
  input  logic              ten_bit_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              byte_vld_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic              addressed_o,
  output logic              gcall_o,
  output logic              irq_o,
  output logic              sec_vld_o,
  output logic [BYTE_W-1:0] sec_byte_o
);
  own_cfg_t cfg_w;
  logic     ten_w;
  logic     busy_w;
  logic     expect_w;
  logic     addr_evt_w;
  logic     gc_hit_w;
  logic     own_hit_w;

  iic_arx_cfg u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_wr_i   (cfg_wr_i),
    .cfg_addr_i (cfg_addr_i),
    .cfg_rw_i   (cfg_rw_i),
    .ten_bit_i  (ten_bit_i),
    .bus_busy_i (busy_w),
    .cfg_o      (cfg_w),
    .ten_q_o    (ten_w)
  );

  iic_arx_cmp u_cmp (
    .byte_i    (byte_i),
    .cfg_i     (cfg_w),
    .ten_i     (ten_w),
    .gc_hit_o  (gc_hit_w),
    .own_hit_o (own_hit_w)
  );

  iic_arx_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .stop_i      (stop_i),
    .byte_vld_i  (byte_vld_i),
    .byte_i      (byte_i),
    .ten_i       (ten_w),
    .gc_hit_i    (gc_hit_w),
    .own_hit_i   (own_hit_w),
    .busy_o      (busy_w),
    .expect_o    (expect_w),
    .addr_evt_o  (addr_evt_w),
    .addressed_o (addressed_o),
    .gcall_o     (gcall_o),
    .irq_o       (irq_o),
    .sec_vld_o   (sec_vld_o),
    .sec_byte_o  (sec_byte_o)
  );
endmodule

// File: rtl/iic_arx_chk.sv
module iic_arx_chk (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic stop_i,
  input logic byte_vld_i,
  input logic addressed_o,
  input logic gcall_o,
  input logic irq_o,
  input logic sec_vld_o,
  input logic expect_w,
  input logic busy_w,
  input logic ten_w,
  input logic addr_evt_w
);
  a_r4_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(addressed_o && gcall_o));

  a_r6_later_byte_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld_i && !expect_w && !start_i && !stop_i)
      |=> ($stable(addressed_o) && $stable(gcall_o)));

  a_r7_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i |=> (!addressed_o && !gcall_o && !busy_w));

  a_r8_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o);

  a_r8_irq_after_eval: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ($past(addr_evt_w) && (addressed_o || gcall_o)));

  a_r9_sec_only_when_addressed: assert property (@(posedge clk) disable iff (!rst_n)
    sec_vld_o |-> (addressed_o && $past(byte_vld_i)));

  a_r10_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    busy_w |=> $stable(ten_w));
endmodule

bind iic_addr_recognizer iic_arx_chk u_arx_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .stop_i      (stop_i),
  .byte_vld_i  (byte_vld_i),
  .addressed_o (addressed_o),
  .gcall_o     (gcall_o),
  .irq_o       (irq_o),
  .sec_vld_o   (sec_vld_o),
  .expect_w    (expect_w),
  .busy_w      (busy_w),
  .ten_w       (ten_w),
  .addr_evt_w  (addr_evt_w)
);

// File: tb/test_iic_addr_recognizer.sv
module test_iic_addr_recognizer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [6:0] cfg_addr = '0;
  logic       cfg_rw = 1'b0;
  logic       ten = 1'b0;
  logic       start = 1'b0;
  logic       stop = 1'b0;
  logic       bvld = 1'b0;
  logic [7:0] bdat = '0;
  logic       addressed, gcall, irq, sec_vld;
  logic [7:0] sec_byte;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  iic_addr_recognizer i_iic_addr_recognizer (
    .clk(clk), .rst_n(rst_n), .cfg_wr_i(cfg_wr), .cfg_addr_i(cfg_addr),
    .cfg_rw_i(cfg_rw), .ten_bit_i(ten), .start_i(start), .stop_i(stop),
    .byte_vld_i(bvld), .byte_i(bdat), .addressed_o(addressed),
    .gcall_o(gcall), .irq_o(irq), .sec_vld_o(sec_vld), .sec_byte_o(sec_byte)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic flags(input string tag, input logic a, input logic g, input logic i);
    chk({tag, " addressed"}, {7'd0, addressed}, {7'd0, a});
    chk({tag, " gcall"},     {7'd0, gcall},     {7'd0, g});
    chk({tag, " irq"},       {7'd0, irq},       {7'd0, i});
  endtask

  task automatic configure(input logic [6:0] a, input logic rw);
    cfg_wr = 1'b1; cfg_addr = a; cfg_rw = rw;
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  task automatic do_start();
    start = 1'b1; @(negedge clk); start = 1'b0;
  endtask

  task automatic do_stop();
    stop = 1'b1; @(negedge clk); stop = 1'b0;
  endtask

  task automatic send(input logic [7:0] b);
    bvld = 1'b1; bdat = b; @(negedge clk); bvld = 1'b0;
  endtask

  task automatic t_reset();
    flags("R1 reset", 1'b0, 1'b0, 1'b0);
    chk("R1 sec_vld", {7'd0, sec_vld}, 8'd0);
  endtask

  task automatic t_seven_bit();
    ten = 1'b0; configure(7'h2A, 1'b0); @(negedge clk);
    do_start(); send(8'h55);
    flags("R2 match rw=1", 1'b1, 1'b0, 1'b1);
    @(negedge clk);
    chk("R8 irq drops", {7'd0, irq}, 8'd0);
    chk("R8 flag held", {7'd0, addressed}, 8'd1);
    do_stop();
    flags("R7 stop clears", 1'b0, 1'b0, 1'b0);
    do_start(); send(8'h54);
    flags("R2 match rw=0", 1'b1, 1'b0, 1'b1);
    do_stop();
  endtask

  task automatic t_nomatch();
    do_start(); send(8'h56);
    flags("R5 mismatch", 1'b0, 1'b0, 1'b0);
    do_start(); send(8'h54); do_start(); send(8'h57);
    flags("R5 rep-start mismatch clears", 1'b0, 1'b0, 1'b0);
    do_stop();
  endtask

  task automatic t_gcall();
    do_start(); send(8'h01);
    flags("R4 general call", 1'b0, 1'b1, 1'b1);
    do_stop();
    configure(7'h00, 1'b1); ten = 1'b1; @(negedge clk);
    do_start(); send(8'h00);
    flags("R4 gcall beats zero addr in 10-bit", 1'b0, 1'b1, 1'b1);
    do_stop(); ten = 1'b0; configure(7'h2A, 1'b0);
  endtask

  task automatic t_later_bytes();
    do_start(); send(8'h54); send(8'h00);
    flags("R6 later gcall byte", 1'b1, 1'b0, 1'b0);
    send(8'h56);
    flags("R6 later mismatch byte", 1'b1, 1'b0, 1'b0);
    do_stop(); send(8'h54);
    flags("R6 byte without start", 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_stop_priority();
    do_start();
    stop = 1'b1; bvld = 1'b1; bdat = 8'h54;
    @(negedge clk); stop = 1'b0; bvld = 1'b0;
    flags("R7 stop beats byte", 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_ten_bit();
    ten = 1'b1; configure(7'h79, 1'b0); @(negedge clk);
    do_start(); send(8'hF3);
    flags("R3 rw differs", 1'b0, 1'b0, 1'b0);
    do_start(); send(8'hF2);
    flags("R3 full match", 1'b1, 1'b0, 1'b1);
    chk("R9 no sec yet", {7'd0, sec_vld}, 8'd0);
    send(8'h34);
    chk("R9 sec valid", {7'd0, sec_vld}, 8'd1);
    chk("R9 sec byte", sec_byte, 8'h34);
    flags("R9 flags kept", 1'b1, 1'b0, 1'b0);
    @(negedge clk);
    chk("R9 sec one cycle", {7'd0, sec_vld}, 8'd0);
    configure(7'h79, 1'b1);
    do_start(); send(8'hF3);
    flags("R11 read after rep start", 1'b1, 1'b0, 1'b1);
    chk("R11 sec stays low", {7'd0, sec_vld}, 8'd0);
    do_stop();
  endtask

  task automatic t_mode_latch();
    ten = 1'b0; configure(7'h2A, 1'b0); @(negedge clk);
    do_start(); ten = 1'b1; @(negedge clk);
    send(8'h55);
    flags("R10 mode held 7-bit", 1'b1, 1'b0, 1'b1);
    do_stop();
    do_start(); send(8'h55);
    flags("R10 new mode 10-bit", 1'b0, 1'b0, 1'b0);
    do_stop(); ten = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_seven_bit();
    t_nomatch();
    t_gcall();
    t_later_bytes();
    t_stop_priority();
    t_ten_bit();
    t_mode_latch();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule